// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Sequencer

This block generates gate-drive timing for a two-channel interleaved buck converter, using only a system clock. A free-running counter of PERIOD clocks serves as both the switching clock and the sawtooth. Each channel receives a digital duty threshold that stands in for the compensated error level. The block drives an upper-switch enable, a lower-switch enable and a one-clock current-sample strobe for each channel.

A switching cycle begins when a channel's upper switch is turned off. For the first third of the cycle, the lower switch is held on and the upper switch cannot be turned on. After that window the upper switch is armed. The lower switch is released when the sawtooth reaches the threshold, and the upper switch turns on GAP clocks later. Channel B runs the same sequence shifted by half a period. A drive-off input clears every gate on the next edge and restarts the sequence from the beginning when it is released.

Top module: `pwm2_seq`

## Requirements
- R1: While rst_n is low, all six outputs are low.
- R2: Outputs are registered. In the k-th clock after the k-th rising edge following release (from reset or from drv_off), channel A shows phase (k-1) mod PERIOD. Phase 0 is cycle start: upper off and lower on. With threshold 0, the first fall of hi_a is seen at k = PERIOD+1, and later falls follow every PERIOD clocks.
- R3: Channel B shows phase (k-1+PERIOD/2) mod PERIOD, so its cycle starts are offset by exactly half a period from channel A's.
- R4: For phases 0 to PERIOD/3-1, lower is high and upper is low, whatever the threshold.
- R5: Let M = max(threshold, PERIOD/3). Lower goes low from phase M, and upper goes high from phase M+GAP.
- R6: Upper and lower of one channel are never high together. Lower is low for GAP clocks before upper rises.
- R7: Once high, upper stays high through phase PERIOD-1 and goes low at phase 0. If M+GAP = PERIOD-1, the pulse is one clock wide.
- R8: smp_x pulses for exactly one clock per cycle, at phase SMP_AT (below PERIOD/3), while lower is high.
- R9: If M+GAP > PERIOD-1, no upper pulse occurs in that cycle and lower stays high for the whole cycle.
- R10: The threshold is captured at phase 0 of each channel's cycle. Changing it at any other phase has no effect until the next cycle.
- R11: When drv_off is high at an edge, all outputs are low after that edge. When drv_off is released, the sequence restarts as in R2. Channel B treats its first partial cycle as having no pulse (lower high) until its phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_off | input | 1 | Protection: forces all gates off and restarts the sequence |
| thr_a | input | $clog2(PERIOD) | Duty threshold, channel A |
| thr_b | input | $clog2(PERIOD) | Duty threshold, channel B |
| hi_a | output | 1 | Upper-switch enable, channel A |
| lo_a | output | 1 | Lower-switch enable, channel A |
| smp_a | output | 1 | Current-sample strobe, channel A |
| hi_b | output | 1 | Upper-switch enable, channel B |
| lo_b | output | 1 | Lower-switch enable, channel B |
| smp_b | output | 1 | Current-sample strobe, channel B |

## Verification
Two events can coincide. The drive-off command can land in the same clock where a channel's pulse is ending or its lower switch is being handed back. Threshold capture at phase 0 can land in the same clock as the previous pulse's turn-off. The bench asserts drv_off while hi_a is high and expects all six outputs low on the following edge. It also changes thr_a in the middle of a pulse and expects the running pulse to finish unchanged, with the new value applied only from the next phase 0. Every clock is compared against a phase model built from the requirements.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
   typedef struct packed {
      logic hi;
      logic lo;
      logic smp;
   } gate_t;
endpackage

// File: rtl/pwm2_period_ctr.sv
module pwm2_period_ctr #(
   parameter int PERIOD = 24,
   localparam int W = $clog2(PERIOD)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (hold)                    cnt <= '0;
      else if (cnt == W'(PERIOD - 1))   cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
   import pwm2_pkg::*;
#(
   parameter int PERIOD = 24,
   parameter int GAP    = 2,
   parameter int SMP_AT = 2,
   parameter int OFFSET = 0,
   localparam int W     = $clog2(PERIOD),
   localparam int PW    = W + 2,
   localparam int THIRD = PERIOD / 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] thr,
   output gate_t        gate
);
   logic [W:0]    sum;
   logic [W-1:0]  ph;
   logic [W-1:0]  thr_q;
   logic [PW-1:0] ph_x, lo_mark, on_mark;
   logic          fits;
   gate_t         gate_n;

   // local phase of this channel
   always_comb begin
      sum = {1'b0, cnt} + (W+1)'(OFFSET);
      if (sum >= (W+1)'(PERIOD)) sum = sum - (W+1)'(PERIOD);
      ph = sum[W-1:0];
   end

   // threshold captured at cycle start; max value means "no pulse"
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr_q <= '1;
      else if (hold)      thr_q <= '1;
      else if (ph == '0)  thr_q <= thr;
   end

   always_comb begin
      ph_x    = PW'(ph);
      lo_mark = (PW'(thr_q) > PW'(THIRD)) ? PW'(thr_q) : PW'(THIRD);
      on_mark = lo_mark + PW'(GAP);
      fits    = (on_mark <= PW'(PERIOD - 1));
      gate_n.hi  = fits && (ph_x >= on_mark);
      gate_n.lo  = !(fits && (ph_x >= lo_mark));
      gate_n.smp = (ph == W'(SMP_AT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    gate <= '0;
      else if (hold) gate <= '0;
      else           gate <= gate_n;
   end
endmodule

// File: rtl/pwm2_seq.sv
module pwm2_seq
   import pwm2_pkg::*;
#(
   parameter int PERIOD = 24,
   parameter int GAP    = 2,
   parameter int SMP_AT = 2,
   localparam int W     = $clog2(PERIOD),
   localparam int NCH   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         drv_off,
   input  logic [W-1:0] thr_a,
   input  logic [W-1:0] thr_b,
   output logic         hi_a,
   output logic         lo_a,
   output logic         smp_a,
   output logic         hi_b,
   output logic         lo_b,
   output logic         smp_b
);
   initial begin
      if (PERIOD % 6 != 0)                     $display("pwm2_seq: PERIOD must be a multiple of 6");
      if (GAP < 1)                             $display("pwm2_seq: GAP must be at least 1");
      if (SMP_AT >= PERIOD / 3)                $display("pwm2_seq: SMP_AT must lie in the forced-off window");
      if (PERIOD / 3 + GAP > PERIOD - 1)       $display("pwm2_seq: GAP leaves no room for a pulse");
   end

   logic [W-1:0] cnt;
   logic [W-1:0] thr [NCH];
   gate_t        g   [NCH];

   assign thr[0] = thr_a;
   assign thr[1] = thr_b;

   pwm2_period_ctr #(.PERIOD(PERIOD)) i_ctr (
      .clk(clk), .rst_n(rst_n), .hold(drv_off), .cnt(cnt)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pwm2_chan #(
         .PERIOD(PERIOD), .GAP(GAP), .SMP_AT(SMP_AT),
         .OFFSET(i * PERIOD / NCH)
      ) i_ch (
         .clk(clk), .rst_n(rst_n), .hold(drv_off),
         .cnt(cnt), .thr(thr[i]), .gate(g[i])
      );
   end

   assign hi_a  = g[0].hi;
   assign lo_a  = g[0].lo;
   assign smp_a = g[0].smp;
   assign hi_b  = g[1].hi;
   assign lo_b  = g[1].lo;
   assign smp_b = g[1].smp;
endmodule

// File: rtl/pwm2_seq_chk.sv
module pwm2_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic drv_off,
   input logic hi_a,
   input logic lo_a,
   input logic smp_a,
   input logic hi_b,
   input logic lo_b,
   input logic smp_b
);
   p_no_overlap_r6_a: assert property (@(posedge clk) disable iff (!rst_n) !(hi_a && lo_a));
   p_no_overlap_r6_b: assert property (@(posedge clk) disable iff (!rst_n) !(hi_b && lo_b));
   p_gap_r6_a: assert property (@(posedge clk) disable iff (!rst_n) $rose(hi_a) |-> !$past(lo_a));
   p_gap_r6_b: assert property (@(posedge clk) disable iff (!rst_n) $rose(hi_b) |-> !$past(lo_b));
   p_smp_in_lo_r8_a: assert property (@(posedge clk) disable iff (!rst_n) smp_a |-> lo_a);
   p_smp_in_lo_r8_b: assert property (@(posedge clk) disable iff (!rst_n) smp_b |-> lo_b);
   p_smp_one_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({smp_a, smp_b}));
   p_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      drv_off |=> !(hi_a || lo_a || smp_a || hi_b || lo_b || smp_b));
   p_end_to_lo_r7_a: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hi_a) && !$past(drv_off)) |-> lo_a);
   p_end_to_lo_r7_b: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hi_b) && !$past(drv_off)) |-> lo_b);
endmodule

bind pwm2_seq pwm2_seq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .drv_off(drv_off),
   .hi_a(hi_a), .lo_a(lo_a), .smp_a(smp_a),
   .hi_b(hi_b), .lo_b(lo_b), .smp_b(smp_b)
);

// File: tb/test_pwm2_seq.sv
module test_pwm2_seq;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 24;
   localparam int D    = 2;
   localparam int S    = 2;
   localparam int W    = $clog2(N);
   localparam int TH   = N / 3;
   localparam int HALF = N / 2;
   localparam int NV   = 7;

   typedef struct packed { logic [W-1:0] t0; logic [W-1:0] t1; } vec_t;
   localparam vec_t VEC [NV] = '{
      '{5'd0,  5'd0},  '{5'd12, 5'd20}, '{5'd21, 5'd21}, '{5'd23, 5'd10},
      '{5'd22, 5'd5},  '{5'd15, 5'd3},  '{5'd9,  5'd8}
   };
   localparam string TAG [NV] = '{"R4", "R5", "R7", "R9", "R9", "R6", "R8"};

   logic clk = 1'b0, rst_n = 1'b0, drv_off = 1'b0;
   logic [W-1:0] thr_a = '0, thr_b = '0;
   logic hi_a, lo_a, smp_a, hi_b, lo_b, smp_b;

   int checks = 0, fails = 0, mk = 0;
   logic [W-1:0] e0 = '1, e1 = '1;
   logic [5:0] expv;

   pwm2_seq #(.PERIOD(N), .GAP(D), .SMP_AT(S)) i_pwm2_seq (
      .clk(clk), .rst_n(rst_n), .drv_off(drv_off), .thr_a(thr_a), .thr_b(thr_b),
      .hi_a(hi_a), .lo_a(lo_a), .smp_a(smp_a), .hi_b(hi_b), .lo_b(lo_b), .smp_b(smp_b)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [2:0] model(int p, int th);
      int  m  = (th < TH) ? TH : th;
      bit  ok = (m + D <= N - 1);
      return {ok && (p >= m + D), !(ok && (p >= m)), p == S};
   endfunction

   task automatic check_v(string tag, logic [5:0] act, logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: outputs {hi_a,lo_a,smp_a,hi_b,lo_b,smp_b} actual=%b expected=%b at %0t",
                  tag, act, exp, $time);
      end
   endtask

   task automatic check_i(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a falling edge with inputs already set for the next rising edge
   task automatic tick(string tag);
      if (!rst_n || drv_off) begin
         expv = '0; mk = 0; e0 = '1; e1 = '1;
      end else begin
         int p0 = mk % N;
         int p1 = (mk + HALF) % N;
         if (p0 == 0) e0 = thr_a;
         if (p1 == 0) e1 = thr_b;
         expv = {model(p0, int'(e0)), model(p1, int'(e1))};
         mk++;
      end
      @(posedge clk);
      @(negedge clk);
      check_v(tag, {hi_a, lo_a, smp_a, hi_b, lo_b, smp_b}, expv);
   endtask

   task automatic restart(logic [W-1:0] a, logic [W-1:0] b);
      thr_a = a; thr_b = b; drv_off = 1'b1;
      tick("R11");
      drv_off = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      @(negedge clk);
      tick("R1");
      tick("R1");
      rst_n = 1'b1;

      // table walk
      for (int v = 0; v < NV; v++) begin
         restart(VEC[v].t0, VEC[v].t1);
         repeat (3 * N) tick(TAG[v]);
      end

      // R2 / R3: positions of the first upper turn-offs
      begin
         int fa1 = -1, fa2 = -1, fb1 = -1;
         logic pa = 1'b0, pb = 1'b0;
         restart('0, '0);
         for (int k = 1; k <= 60; k++) begin
            tick("R2");
            if (pa && !hi_a) begin if (fa1 < 0) fa1 = k; else if (fa2 < 0) fa2 = k; end
            if (pb && !hi_b && fb1 < 0) fb1 = k;
            pa = hi_a; pb = hi_b;
         end
         check_i("R2 first fall of hi_a", fa1, N + 1);
         check_i("R2 second fall of hi_a", fa2, 2 * N + 1);
         check_i("R3 first fall of hi_b", fb1, N + 1 + HALF);
      end

      // R10: threshold moved mid-pulse takes effect only next cycle
      restart('0, 5'd4);
      repeat (15) tick("R10");
      thr_a = 5'd30; thr_b = 5'd30;
      repeat (2 * N) tick("R10");

      // R11: drive-off lands while hi_a is high, then clean restart
      restart('0, '0);
      repeat (20) tick("R11");
      check_i("R11 hi_a high before drive-off", int'(hi_a), 1);
      drv_off = 1'b1;
      tick("R11");
      drv_off = 1'b0;
      repeat (2 * N) tick("R11");

      // R1: reset in mid-run
      rst_n = 1'b0;
      tick("R1");
      rst_n = 1'b1;
      repeat (N) tick("R2");

      summary();
   end
endmodule